// File: doc/BRIEF.md
# Configuration Test Access Port

This block is the serial configuration port of a mixed-signal chip. It follows the 1149.1 test access port protocol: the standard 16-state controller is driven by TCK and TMS, with a 5-bit instruction register. The port holds no boundary-scan cells. Its data registers are a 1-bit bypass register, a 32-bit identification word and a 96-bit user register. Its instructions act on two non-volatile configuration banks, A and B. These instructions erase a bank, program a bank, read a bank back, and start the analog calibration.

The non-volatile memory is modelled as two register banks and one busy timer counted in system clocks. TCK, TMS and TDI are synchronised into the system clock domain. TCK edges are found there, so all state sits in one clock domain. The analog side reads both banks on `cfg_a_o` and `cfg_b_o`, and watches `cal_o` while a calibration runs.

Top module: `jcfg_port`

## Requirements
- R1: Five TCK rising edges with TMS high bring the controller to Test-Logic-Reset from any state. In that state the active instruction becomes IDCODE (5'b01101).
- R2: After reset, and with no instruction loaded, a DR scan shifts out the 32-bit identification word LSB first. From MSB to LSB the word is: version (4 bits, parameter), part number 16'h0121, manufacturer code 11'b00000100001, and a constant 1.
- R3: Capture-IR loads 5'b01101 into the instruction shifter, and it is shifted out LSB first.
- R4: The codes 5'b00000, 5'b11110, 5'b11111, and every code not listed in R6 to R11, select the 1-bit bypass register. This register captures 0, so TDO repeats TDI one TCK later.
- R5: TMS and TDI are sampled on TCK rising edges. TDO changes only after TCK falling edges. `tdo_en_o` is high only while in Shift-IR or Shift-DR.
- R6: The codes 5'b00001 (user access), 5'b00110/5'b00111 (program A/B) and 5'b00100/5'b00101 (verify A/B) select the 96-bit user register. Capture-DR leaves this register unchanged.
- R7: A program command ORs the user register into its bank, so bits can only be set. Bank B keeps only bits [70:0]; its other bits stay 0.
- R8: A bulk-erase command (5'b00010 for A, 5'b00011 for B) clears the whole bank to zero.
- R9: A verify command loads the bank into the user register. Verify A loads all zeros when bank A bit 73 (wake-up select) is 1. Every verify loads all zeros while bank A bit 95 (security) is 1, and this lasts until bank A is erased.
- R10: Erase and program raise `busy_o` for PROG_CYCLES system clocks, and calibration raises it for CAL_CYCLES. While `busy_o` is high, any new memory command is dropped.
- R11: Code 5'b01100 starts a calibration. `cal_o` goes high and stays high for the calibration time.
- R12: Memory and calibration commands run only on the TCK edge that enters Run-Test/Idle from Update-IR or Update-DR. Staying in Run-Test/Idle starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; TCK is oversampled with it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tck_i | input | 1 | Test clock |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| tdo_en_o | output | 1 | Output enable of TDO; low means high impedance |
| busy_o | output | 1 | Memory or calibration timer running |
| cal_o | output | 1 | Calibration in progress |
| cfg_a_o | output | 96 | Contents of configuration bank A |
| cfg_b_o | output | 96 | Contents of configuration bank B |

## Verification
Two functions can fall in the same cycle: a command arriving on Run-Test/Idle entry, and a busy timer that is still counting. The bench starts a program of bank B. At once it loads a bank A erase and enters Run-Test/Idle while `busy_o` is still high. The erase counts as dropped only if `cfg_a_o` still shows its programmed pattern. The verify-blocking checks combine a readout with the security and wake-up bits. Each combination is judged by the value shifted out on TDO.

// File: rtl/jcfg_pkg.sv
package jcfg_pkg;
  localparam int unsigned IR_W = 5;
  localparam int unsigned ID_W = 32;
  localparam int unsigned UW   = 96;
  localparam int unsigned AB_BIT  = 73;
  localparam int unsigned SEC_BIT = 95;
  localparam int unsigned B_KEEP  = 71;
  localparam logic [UW-1:0] B_KEEP_MASK = {{(UW-B_KEEP){1'b0}}, {B_KEEP{1'b1}}};

  localparam logic [IR_W-1:0] I_ADDUSR = 5'b00001;
  localparam logic [IR_W-1:0] I_ERA_A  = 5'b00010;
  localparam logic [IR_W-1:0] I_ERA_B  = 5'b00011;
  localparam logic [IR_W-1:0] I_VER_A  = 5'b00100;
  localparam logic [IR_W-1:0] I_VER_B  = 5'b00101;
  localparam logic [IR_W-1:0] I_PRG_A  = 5'b00110;
  localparam logic [IR_W-1:0] I_PRG_B  = 5'b00111;
  localparam logic [IR_W-1:0] I_CAL    = 5'b01100;
  localparam logic [IR_W-1:0] I_IDCODE = 5'b01101;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {OP_NONE, OP_ERASE, OP_PROG, OP_VERIFY, OP_CAL} nvm_op_e;
  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_USR} dr_sel_e;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    unique case (s)
      TLR:    return m ? TLR    : RTI;
      RTI:    return m ? SEL_DR : RTI;
      SEL_DR: return m ? SEL_IR : CAP_DR;
      CAP_DR: return m ? EX1_DR : SH_DR;
      SH_DR:  return m ? EX1_DR : SH_DR;
      EX1_DR: return m ? UPD_DR : PAU_DR;
      PAU_DR: return m ? EX2_DR : PAU_DR;
      EX2_DR: return m ? UPD_DR : SH_DR;
      UPD_DR: return m ? SEL_DR : RTI;
      SEL_IR: return m ? TLR    : CAP_IR;
      CAP_IR: return m ? EX1_IR : SH_IR;
      SH_IR:  return m ? EX1_IR : SH_IR;
      EX1_IR: return m ? UPD_IR : PAU_IR;
      PAU_IR: return m ? EX2_IR : PAU_IR;
      EX2_IR: return m ? UPD_IR : SH_IR;
      default: return m ? SEL_DR : RTI;
    endcase
  endfunction
endpackage

// File: rtl/jcfg_sync.sv
module jcfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[gs] <= '0;
      else         pipe_q[gs] <= (gs == 0) ? d_i : pipe_q[(gs == 0) ? 0 : gs-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/jcfg_tap_fsm.sv
module jcfg_tap_fsm import jcfg_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tck_rise_i,
  input  logic       tms_i,
  output tap_state_e state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_o <= TLR;
    else if (tck_rise_i) state_o <= tap_next(state_o, tms_i);
  end

  // R5
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tck_rise_i |=> $stable(state_o));
endmodule

// File: rtl/jcfg_nvm.sv
module jcfg_nvm import jcfg_pkg::*; #(
  parameter int unsigned PROG_CYCLES = 800000,
  parameter int unsigned CAL_CYCLES  = 1000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_v_i,
  input  nvm_op_e       op_i,
  input  logic          bank_b_i,
  input  logic [UW-1:0] wdata_i,
  output logic          busy_o,
  output logic          cal_o,
  output logic [UW-1:0] rd_data_o,
  output logic [UW-1:0] bank_a_o,
  output logic [UW-1:0] bank_b_o
);
  localparam int unsigned MAXC  = (PROG_CYCLES > CAL_CYCLES) ? PROG_CYCLES : CAL_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic [1:0][UW-1:0] bank_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               cal_q;
  logic               accept;

  assign accept = cmd_v_i && !busy_o;

  for (genvar gb = 0; gb < 2; gb++) begin : g_bank
    localparam logic [UW-1:0] KEEP = (gb == 0) ? {UW{1'b1}} : B_KEEP_MASK;
    logic hit;
    assign hit = accept && (bank_b_i == (gb == 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    bank_q[gb] <= '0;
      else if (hit && op_i == OP_ERASE) bank_q[gb] <= '0;
      else if (hit && op_i == OP_PROG)  bank_q[gb] <= bank_q[gb] | (wdata_i & KEEP);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cal_q <= 1'b0;
    end else if (accept && (op_i == OP_ERASE || op_i == OP_PROG)) begin
      cnt_q <= CNT_W'(PROG_CYCLES);
      cal_q <= 1'b0;
    end else if (accept && op_i == OP_CAL) begin
      cnt_q <= CNT_W'(CAL_CYCLES);
      cal_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      cal_q <= 1'b0;
    end
  end

  logic blocked;
  assign blocked   = bank_q[0][SEC_BIT] || (!bank_b_i && bank_q[0][AB_BIT]);
  assign rd_data_o = blocked ? '0 : (bank_b_i ? bank_q[1] : bank_q[0]);
  assign busy_o    = (cnt_q != '0);
  assign cal_o     = cal_q && busy_o;
  assign bank_a_o  = bank_q[0];
  assign bank_b_o  = bank_q[1];

  // R7
  prog_or_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_v_i && op_i == OP_ERASE) |=> ((bank_q[0] & $past(bank_q[0])) == $past(bank_q[0])));
  // R8
  erase_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_i == OP_ERASE && !bank_b_i) |=> (bank_q[0] == '0));
  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(bank_q));
  // R11
  cal_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_o) |-> $past(cmd_v_i && op_i == OP_CAL));
endmodule

// File: rtl/jcfg_port.sv
module jcfg_port import jcfg_pkg::*; #(
  parameter logic [3:0]  ID_VERSION  = 4'h0,
  parameter int unsigned PROG_CYCLES = 800000,
  parameter int unsigned CAL_CYCLES  = 1000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tck_i,
  input  logic          tms_i,
  input  logic          tdi_i,
  output logic          tdo_o,
  output logic          tdo_en_o,
  output logic          busy_o,
  output logic          cal_o,
  output logic [UW-1:0] cfg_a_o,
  output logic [UW-1:0] cfg_b_o
);
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, 16'h0121, 11'b00000100001, 1'b1};

  logic [2:0] pin_s;
  logic       tck_s, tms_s, tdi_s, tck_d;
  logic       tck_rise, tck_fall;

  jcfg_sync #(.W(3), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i({tck_i, tms_i, tdi_i}), .q_o(pin_s)
  );
  assign {tck_s, tms_s, tdi_s} = pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tck_d <= 1'b0;
    else         tck_d <= tck_s;
  end
  assign tck_rise = tck_s && !tck_d;
  assign tck_fall = !tck_s && tck_d;

  tap_state_e state_q;
  jcfg_tap_fsm u_fsm (
    .clk_i, .rst_ni, .tck_rise_i(tck_rise), .tms_i(tms_s), .state_o(state_q)
  );

  logic [IR_W-1:0] ir_sr, ir_q, cmd_ir;
  logic [ID_W-1:0] id_sr;
  logic [UW-1:0]   usr_sr, rd_data;
  logic            byp_q;
  dr_sel_e         dr_sel;
  nvm_op_e         op;
  logic            op_bank_b, cmd_v;

  always_comb begin
    unique case (ir_q)
      I_IDCODE:                                    dr_sel = DR_ID;
      I_ADDUSR, I_PRG_A, I_PRG_B, I_VER_A, I_VER_B: dr_sel = DR_USR;
      default:                                     dr_sel = DR_BYP;
    endcase
  end

  // Update-IR issues with the new instruction, Update-DR with the held one
  assign cmd_ir = (state_q == UPD_IR) ? ir_sr : ir_q;

  always_comb begin
    op_bank_b = cmd_ir[0];
    unique case (cmd_ir)
      I_ERA_A, I_ERA_B: op = OP_ERASE;
      I_PRG_A, I_PRG_B: op = OP_PROG;
      I_VER_A, I_VER_B: op = OP_VERIFY;
      I_CAL:            op = OP_CAL;
      default:          op = OP_NONE;
    endcase
  end

  assign cmd_v = tck_rise && !tms_s && (op != OP_NONE) &&
                 (state_q == UPD_IR || state_q == UPD_DR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_sr  <= I_IDCODE;
      ir_q   <= I_IDCODE;
      id_sr  <= '0;
      usr_sr <= '0;
      byp_q  <= 1'b0;
    end else if (cmd_v && op == OP_VERIFY && !busy_o) begin
      usr_sr <= rd_data;
      if (state_q == UPD_IR) ir_q <= ir_sr;
    end else if (tck_rise) begin
      unique case (state_q)
        TLR:    ir_q  <= I_IDCODE;
        CAP_IR: ir_sr <= I_IDCODE;
        SH_IR:  ir_sr <= {tdi_s, ir_sr[IR_W-1:1]};
        UPD_IR: ir_q  <= ir_sr;
        CAP_DR: begin
          byp_q <= 1'b0;
          if (dr_sel == DR_ID) id_sr <= ID_WORD;
        end
        SH_DR: begin
          unique case (dr_sel)
            DR_ID:   id_sr  <= {tdi_s, id_sr[ID_W-1:1]};
            DR_USR:  usr_sr <= {tdi_s, usr_sr[UW-1:1]};
            default: byp_q  <= tdi_s;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else if (tck_fall) begin
      tdo_en_o <= (state_q == SH_IR) || (state_q == SH_DR);
      if (state_q == SH_IR)      tdo_o <= ir_sr[0];
      else if (state_q == SH_DR) tdo_o <= (dr_sel == DR_ID)  ? id_sr[0] :
                                          (dr_sel == DR_USR) ? usr_sr[0] : byp_q;
      else                       tdo_o <= 1'b0;
    end
  end

  jcfg_nvm #(.PROG_CYCLES(PROG_CYCLES), .CAL_CYCLES(CAL_CYCLES)) u_nvm (
    .clk_i, .rst_ni, .cmd_v_i(cmd_v), .op_i(op), .bank_b_i(op_bank_b),
    .wdata_i(usr_sr), .busy_o, .cal_o, .rd_data_o(rd_data),
    .bank_a_o(cfg_a_o), .bank_b_o(cfg_b_o)
  );

  // R5
  tdo_en_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tdo_en_o) |-> (state_q == SH_IR || state_q == SH_DR));
  // R12
  cmd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_rise && state_q == RTI) |-> !cmd_v);
endmodule

// File: tb/jcfg_port_tb.sv
module jcfg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_T = 2000;
  localparam int CAL_T  = 300;

  localparam logic [4:0] C_EXTEST = 5'b00000, C_ADDUSR = 5'b00001, C_ABE = 5'b00010,
                         C_BBE = 5'b00011, C_VERA = 5'b00100, C_VERB = 5'b00101,
                         C_PRGA = 5'b00110, C_PRGB = 5'b00111, C_CAL = 5'b01100,
                         C_ID = 5'b01101, C_SAMPLE = 5'b11110, C_BYP = 5'b11111;
  localparam logic [31:0] EXP_ID = {4'h0, 16'h0121, 11'b00000100001, 1'b1};
  localparam logic [95:0] MASK_B = {25'b0, {71{1'b1}}};
  localparam logic [95:0] FREE_A = ~((96'b1 << 73) | (96'b1 << 95));

  logic clk = 1'b0, rst_n = 1'b0, tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, busy, cal;
  logic [95:0] cfg_a, cfg_b;
  logic [95:0] ma, mb;
  int n_chk = 0, n_bad = 0;
  logic en_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  jcfg_port #(.ID_VERSION(4'h0), .PROG_CYCLES(PROG_T), .CAL_CYCLES(CAL_T)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tck_i(tck), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_en_o(tdo_en), .busy_o(busy), .cal_o(cal),
    .cfg_a_o(cfg_a), .cfg_b_o(cfg_b)
  );

  task automatic chk(input string req, input string what, input logic [95:0] act,
                     input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  task automatic tck_cycle(input logic m, input logic d);
    @(negedge clk); tms = m; tdi = d;
    repeat (2) @(negedge clk); tck = 1'b1;
    repeat (8) @(negedge clk); tck = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic shift_ir(input logic [4:0] code, output logic [4:0] cap);
    tck_cycle(1, 0); tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
    for (int i = 0; i < 5; i++) begin
      cap[i] = tdo;
      tck_cycle(i == 4, code[i]);
    end
    tck_cycle(1, 0); tck_cycle(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [95:0] din, output logic [95:0] dout);
    dout = '0;
    tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
    en_seen = tdo_en;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tck_cycle(i == n-1, din[i]);
    end
    tck_cycle(1, 0); tck_cycle(0, 0);
  endtask

  task automatic load_ir(input logic [4:0] code);
    logic [4:0] c;
    shift_ir(code, c);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic prog_bank(input logic b, input logic [95:0] d);
    logic [95:0] o;
    load_ir(C_ADDUSR);
    shift_dr(96, d, o);
    load_ir(b ? C_PRGB : C_PRGA);
    if (b) mb = mb | (d & MASK_B); else ma = ma | d;
    wait_idle();
  endtask

  task automatic read_bank(input logic b, output logic [95:0] o);
    load_ir(b ? C_VERB : C_VERA);
    shift_dr(96, '0, o);
  endtask

  task automatic t_reset();
    chk("R5", "tdo_en after reset", {95'b0, tdo_en}, 96'b0);
    chk("R10", "busy after reset", {95'b0, busy}, 96'b0);
    chk("R8", "bank A after reset", cfg_a, 96'b0);
  endtask

  task automatic t_idcode();
    logic [95:0] o;
    tck_cycle(0, 0);
    shift_dr(32, '0, o);
    chk("R2", "id word", o, {64'b0, EXP_ID});
    chk("R5", "tdo_en in Shift-DR", {95'b0, en_seen}, 96'b1);
    chk("R5", "tdo_en in Run-Test/Idle", {95'b0, tdo_en}, 96'b0);
  endtask

  task automatic t_ir_capture();
    logic [4:0] c;
    shift_ir(C_BYP, c);
    chk("R3", "captured IR", {91'b0, c}, {91'b0, 5'b01101});
  endtask

  task automatic t_bypass(input logic [4:0] code);
    logic [95:0] o;
    load_ir(code);
    shift_dr(8, 96'hA5, o);
    chk("R4", $sformatf("bypass code %b", code), o, {88'b0, 8'h4A});
  endtask

  task automatic t_prog_or();
    logic [95:0] p1, p2, o;
    p1 = 96'h0123_4567_89AB_CDEF_0F0F_1234 & FREE_A;
    p2 = 96'h0000_0000_0000_F000_0000_00F1 & FREE_A;
    load_ir(C_ABE); ma = '0; wait_idle();
    chk("R8", "bank A erased", cfg_a, 96'b0);
    prog_bank(0, p1);
    prog_bank(0, p2);
    chk("R7", "bank A OR of two programs", cfg_a, p1 | p2);
    read_bank(0, o);
    chk("R9", "verify A readout", o, ma);
    load_ir(C_ADDUSR);
    shift_dr(96, 96'h5, o);
    chk("R6", "user reg holds verify data", o, ma);
  endtask

  task automatic t_prog_b();
    logic [95:0] o;
    prog_bank(1, {96{1'b1}});
    chk("R7", "bank B keeps low 71 bits", cfg_b, mb);
    load_ir(C_BBE); mb = '0; wait_idle();
    chk("R8", "bank B erased", cfg_b, 96'b0);
    prog_bank(1, 96'hFFFF_0000_1111_2222_3333_4444);
    read_bank(1, o);
    chk("R9", "verify B readout", o, mb);
  endtask

  task automatic t_busy();
    logic [95:0] o;
    load_ir(C_ADDUSR);
    shift_dr(96, 96'h0F, o);
    load_ir(C_PRGB);
    mb = mb | 96'h0F;
    chk("R10", "busy after program", {95'b0, busy}, 96'b1);
    load_ir(C_ABE);
    chk("R10", "still busy at erase", {95'b0, busy}, 96'b1);
    chk("R10", "erase dropped while busy", cfg_a, ma);
    wait_idle();
    chk("R10", "bank A after busy ends", cfg_a, ma);
  endtask

  task automatic t_block();
    logic [95:0] o;
    prog_bank(0, 96'b1 << 73);
    read_bank(0, o);
    chk("R9", "verify A blocked by A/B bit", o, 96'b0);
    read_bank(1, o);
    chk("R9", "verify B open with A/B bit", o, mb);
    prog_bank(0, 96'b1 << 95);
    read_bank(1, o);
    chk("R9", "verify B blocked by security", o, 96'b0);
    load_ir(C_ABE); ma = '0; wait_idle();
    read_bank(1, o);
    chk("R9", "verify B after erase A", o, mb);
    read_bank(0, o);
    chk("R9", "verify A after erase A", o, 96'b0);
  endtask

  task automatic t_cal();
    load_ir(C_CAL);
    chk("R11", "cal high", {95'b0, cal}, 96'b1);
    chk("R10", "busy during cal", {95'b0, busy}, 96'b1);
    wait_idle();
    chk("R11", "cal low after timer", {95'b0, cal}, 96'b0);
    for (int i = 0; i < 10; i++) tck_cycle(0, 0);
    chk("R12", "no restart in Run-Test/Idle", {94'b0, cal, busy}, 96'b0);
  endtask

  task automatic t_tlr();
    logic [95:0] o;
    load_ir(C_BYP);
    tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
    for (int i = 0; i < 5; i++) tck_cycle(1, 0);
    chk("R5", "tdo_en after reset walk", {95'b0, tdo_en}, 96'b0);
    tck_cycle(0, 0);
    shift_dr(32, '0, o);
    chk("R1", "IDCODE active after TMS reset", o, {64'b0, EXP_ID});
  endtask

  initial begin
    ma = '0; mb = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idcode();
    t_ir_capture();
    t_bypass(C_EXTEST);
    t_bypass(C_SAMPLE);
    t_bypass(C_BYP);
    t_bypass(5'b01010);
    t_prog_or();
    t_prog_b();
    t_busy();
    t_block();
    t_cal();
    t_tlr();
    finish_run();
  end
endmodule